// File: doc/BRIEF.md
# Table-Driven DMA Channel Scheduler

This block decides which DMA channel may move data next. Software fills a table of one-byte entries through a word-wide register port. Each entry names a channel and a direction, transmit or receive. Software then writes the control register. That write sets the enable flag and the index of the last entry in use. While enabled, the scheduler looks at one entry per clock and steps through the table in order. After the last programmed entry it goes back to entry 0.

For each entry it checks the request line of the named channel in the named direction. If that line is high, it issues a single-cycle grant naming the channel and direction. If not, the entry is passed over. The pointer moves on in both cases, so a channel appears in the grant stream as often as it appears in the table. Software sets each channel's share of the bandwidth by how often it lists that channel.

The grant is a one-cycle strobe with no ready signal. The data movers must accept it or let it pass, and the scheduler never stalls on them. The register port is a plain write and read strobe with registered read data.

Top module: `dma_sched_table`

## Requirements
- R1: After reset the scheduler is disabled, the entry pointer is 0, no grant is issued, and read data is 0.
- R2: The table occupies word addresses 0x800 + 4*w for w below TABLE_WORDS. Each 32-bit word holds four entries, with entry 4*w+k in bits 8k+7..8k. A read returns the last value written to that word one cycle after the read strobe. A read of any address outside the control register and the table returns 0.
- R3: The control register sits at address 0. Bit 31 is the enable flag and bits IDX_W-1..0 hold the last entry index. A read returns those fields with all other bits 0.
- R4: While the enable flag is clear, grant_valid stays low and requests have no effect.
- R5: While enabled, the scheduler examines one entry per clock. If the entry's request is high at that edge, grant_valid is high in the following cycle. In that cycle grant_chan equals entry bits 6..0 and grant_rx equals entry bit 7 (1 = receive, 0 = transmit, selecting rx_req or tx_req).
- R6: An entry whose request is low gives no grant, and the next clock examines the following entry.
- R7: After the entry whose index equals the last index has been examined, the next examined entry is entry 0. A last index of 0 examines entry 0 every clock.
- R8: Any write to the control register returns the pointer to entry 0 and suppresses the grant for that cycle. The walk restarts at entry 0 on the next clock.
- R9: An entry whose channel field is NUM_CHAN or above never produces a grant, but it still uses one step of the walk.
- R10: A table write made while the scheduler runs takes effect the next time the walk reaches the rewritten entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| tx_req | input | NUM_CHAN | Per-channel transmit request |
| rx_req | input | NUM_CHAN | Per-channel receive request |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_chan | output | CHAN_W | Channel being granted |
| grant_rx | output | 1 | 1 when the grant is for receive |

## Verification
The assertions assume that the request vectors and register strobes change only between clock edges. They also assume the last index stays within the implemented table, because the wrap logic is only checked for the pointer range the table covers. The stimulus therefore drives every input a short time after the rising edge. It writes last-index values from 0 up to the final table entry. It also rewrites table words and the control register while a walk is in progress, so the restart and the late-update timing are exercised as well as the steady walk.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned EN_BIT     = 31;
  localparam int unsigned ENTRY_W    = 8;
  localparam int unsigned ENTRIES_PER_WORD = REG_W / ENTRY_W;
  localparam logic [11:0] CTRL_ADDR  = 12'h000;
  localparam logic [11:0] TBL_BASE   = 12'h800;

  typedef struct packed {
    logic       rx;
    logic [6:0] chan;
  } sched_entry_t;

endpackage

// File: rtl/sched_regs.sv
module sched_regs
  import dma_sched_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned TABLE_WORDS = 32,
  parameter int unsigned IDX_W       = 7,
  parameter int unsigned WORD_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              sched_en,
  output logic [IDX_W-1:0]  last_idx,
  output logic              ctl_wr,
  input  logic [IDX_W-1:0]  look_idx,
  output sched_entry_t      look_entry
);

  logic [REG_W-1:0]  tbl [TABLE_WORDS];
  logic [ADDR_W-1:0] offs;
  logic [WORD_W-1:0] word_sel;
  logic              ctrl_hit;
  logic              tbl_hit;
  logic [REG_W-1:0]  ctrl_word;
  logic [REG_W-1:0]  look_word;

  assign offs     = addr - ADDR_W'(TBL_BASE);
  assign word_sel = offs[2 +: WORD_W];
  assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));
  assign tbl_hit  = (addr >= ADDR_W'(TBL_BASE)) && (offs[1:0] == 2'b00) &&
                    ((32'(offs) >> 2) < TABLE_WORDS);
  assign ctl_wr   = wr_en && ctrl_hit;

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[EN_BIT]      = sched_en;
    ctrl_word[IDX_W-1:0]   = last_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched_en <= 1'b0;
      last_idx <= '0;
    end else if (ctl_wr) begin
      sched_en <= wdata[EN_BIT];
      last_idx <= wdata[IDX_W-1:0];
    end
  end

  for (genvar w = 0; w < TABLE_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl[w] <= '0;
      else if (wr_en && tbl_hit && (word_sel == WORD_W'(w)))
        tbl[w] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en) begin
      if (ctrl_hit)     rdata <= ctrl_word;
      else if (tbl_hit) rdata <= tbl[word_sel];
      else              rdata <= '0;
    end
  end

  assign look_word  = tbl[look_idx[IDX_W-1:2]];
  assign look_entry = sched_entry_t'(look_word[ENTRY_W*look_idx[1:0] +: ENTRY_W]);

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (sched_en == $past(wdata[EN_BIT])) &&
               (last_idx == $past(wdata[IDX_W-1:0])));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/sched_walker.sv
module sched_walker
  import dma_sched_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 32,
  parameter int unsigned IDX_W    = 7,
  parameter int unsigned CHAN_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sched_en,
  input  logic [IDX_W-1:0]    last_idx,
  input  logic                ctl_wr,
  input  sched_entry_t        cur_entry,
  input  logic [NUM_CHAN-1:0] tx_req,
  input  logic [NUM_CHAN-1:0] rx_req,
  output logic [IDX_W-1:0]    ptr,
  output logic                grant_valid,
  output logic [CHAN_W-1:0]   grant_chan,
  output logic                grant_rx
);

  logic              in_range;
  logic [CHAN_W-1:0] sel;
  logic              hit;
  logic              wrap;

  assign in_range = int'(cur_entry.chan) < NUM_CHAN;
  assign sel      = cur_entry.chan[CHAN_W-1:0];
  assign hit      = in_range && (cur_entry.rx ? rx_req[sel] : tx_req[sel]);
  assign wrap     = (ptr >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr         <= '0;
      grant_valid <= 1'b0;
      grant_chan  <= '0;
      grant_rx    <= 1'b0;
    end else if (ctl_wr) begin
      ptr         <= '0;
      grant_valid <= 1'b0;
    end else if (sched_en) begin
      grant_valid <= hit;
      if (hit) begin
        grant_chan <= sel;
        grant_rx   <= cur_entry.rx;
      end
      ptr <= wrap ? '0 : ptr + 1'b1;
    end else begin
      grant_valid <= 1'b0;
    end
  end

  logic [NUM_CHAN-1:0] tx_d, rx_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_d <= '0;
      rx_d <= '0;
    end else begin
      tx_d <= tx_req;
      rx_d <= rx_req;
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_en |=> !grant_valid);

  // R5
  req_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_rx ? rx_d[grant_chan] : tx_d[grant_chan]));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && !ctl_wr && (ptr < last_idx)) |=> (ptr == $past(ptr) + 1'b1));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_en && !ctl_wr && (ptr >= last_idx)) |=> (ptr == '0));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ptr == '0) && !grant_valid);

endmodule

// File: rtl/dma_sched_table.sv
module dma_sched_table
  import dma_sched_pkg::*;
#(
  parameter int unsigned NUM_CHAN    = 32,
  parameter int unsigned TABLE_WORDS = 32,
  parameter int unsigned ADDR_W      = 12,
  localparam int unsigned NUM_ENTRIES = TABLE_WORDS * ENTRIES_PER_WORD,
  localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES),
  localparam int unsigned WORD_W      = $clog2(TABLE_WORDS),
  localparam int unsigned CHAN_W      = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_CHAN-1:0] tx_req,
  input  logic [NUM_CHAN-1:0] rx_req,
  output logic                grant_valid,
  output logic [CHAN_W-1:0]   grant_chan,
  output logic                grant_rx
);

  logic             sched_en;
  logic [IDX_W-1:0] last_idx;
  logic             ctl_wr;
  logic [IDX_W-1:0] ptr;
  sched_entry_t     cur_entry;

  sched_regs #(
    .ADDR_W      (ADDR_W),
    .TABLE_WORDS (TABLE_WORDS),
    .IDX_W       (IDX_W),
    .WORD_W      (WORD_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .sched_en   (sched_en),
    .last_idx   (last_idx),
    .ctl_wr     (ctl_wr),
    .look_idx   (ptr),
    .look_entry (cur_entry)
  );

  sched_walker #(
    .NUM_CHAN (NUM_CHAN),
    .IDX_W    (IDX_W),
    .CHAN_W   (CHAN_W)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .sched_en    (sched_en),
    .last_idx    (last_idx),
    .ctl_wr      (ctl_wr),
    .cur_entry   (cur_entry),
    .tx_req      (tx_req),
    .rx_req      (rx_req),
    .ptr         (ptr),
    .grant_valid (grant_valid),
    .grant_chan  (grant_chan),
    .grant_rx    (grant_rx)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !grant_valid);

endmodule

// File: tb/dma_sched_table_bench.sv
module dma_sched_table_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 32;
  localparam int NWORD = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] tx_req = '0;
  logic [NCH-1:0] rx_req = '0;
  logic        grant_valid;
  logic [4:0]  grant_chan;
  logic        grant_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_sched_table u_dma_sched_table (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata),
    .tx_req (tx_req), .rx_req (rx_req),
    .grant_valid (grant_valid), .grant_chan (grant_chan), .grant_rx (grant_rx)
  );

  // behavioural reference
  int          m_tbl [NWORD];
  bit          m_en = 0;
  int          m_last = 0;
  int          m_ptr = 0;
  bit          e_gv = 0;
  int          e_ch = 0;
  bit          e_rx = 0;
  logic [31:0] e_rdata = '0;

  int    vectors = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  function automatic logic [31:0] model_read(int a);
    if (a == 0) return {m_en, 24'd0, 7'(m_last)};
    if (a >= 'h800 && a < 'h800 + 4*NWORD && (a % 4) == 0)
      return m_tbl[(a - 'h800) / 4];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) m_tbl[i] = 0;
      m_en = 0; m_last = 0; m_ptr = 0; e_gv = 0; e_ch = 0; e_rx = 0; e_rdata = '0;
    end else begin
      logic [31:0] nr;
      nr = e_rdata;
      if (rd_en) nr = model_read(int'(addr));
      if (wr_en && addr == 0) begin
        m_en = wdata[31]; m_last = int'(wdata[6:0]); m_ptr = 0; e_gv = 0;
      end else if (m_en) begin
        int b, ch;
        bit rx;
        b  = (m_tbl[m_ptr/4] >> (8*(m_ptr%4))) & 'hff;
        ch = b & 'h7f;
        rx = b[7];
        e_gv = (ch < NCH) && (rx ? rx_req[ch] : tx_req[ch]);
        if (e_gv) begin e_ch = ch; e_rx = rx; end
        m_ptr = (m_ptr >= m_last) ? 0 : m_ptr + 1;
      end else begin
        e_gv = 0;
      end
      if (wr_en && addr >= 'h800 && addr < 'h800 + 4*NWORD && addr[1:0] == 0)
        m_tbl[(int'(addr) - 'h800) / 4] = wdata;
      e_rdata = nr;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (grant_valid !== e_gv) begin
        fails++;
        $display("FAIL %s grant_valid actual %0b expected %0b at cycle %0d", cur_req, grant_valid, e_gv, cyc);
      end else if (e_gv && (grant_chan !== 5'(e_ch) || grant_rx !== e_rx)) begin
        fails++;
        $display("FAIL %s grant chan/rx actual %0d/%0b expected %0d/%0b at cycle %0d",
                 cur_req, grant_chan, grant_rx, e_ch, e_rx, cyc);
      end
      if (rdata !== e_rdata) begin
        fails++;
        $display("FAIL %s rdata actual %h expected %h at cycle %0d", cur_req, rdata, e_rdata, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d; tick(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    rd_en = 1'b1; addr = a; tick(); rd_en = 1'b0;
  endtask

  // mode 0 random, 1 all set, 2 all clear
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: begin tx_req = $urandom(); rx_req = $urandom(); end
        1: begin tx_req = '1; rx_req = '1; end
        default: begin tx_req = '0; rx_req = '0; end
      endcase
      tick();
    end
  endtask

  initial begin
    void'($urandom(13));
    repeat (4) tick();
    // R1: reset state, control and table read as zero
    cur_req = "R1";
    rst_n = 1'b1; tick();
    rd(12'h000); rd(12'h800);
    run(4, 1);
    // R2: table programming and read-back, TX/RX pairs over channel pairs
    cur_req = "R2";
    for (int w = 0; w < 15; w++) begin
      int c;
      c = 2*w;
      wr(12'(12'h800 + 4*w), {8'(8'h80 | (c+1)), 8'(c+1), 8'(8'h80 | c), 8'(c)});
    end
    // R9 entries with channel numbers outside the implemented range
    wr(12'h83c, {8'hff, 8'h40, 8'ha0, 8'h20});
    for (int w = 16; w < NWORD; w++) wr(12'(12'h800 + 4*w), $urandom());
    rd(12'h800); rd(12'h81c); rd(12'h83c); rd(12'h87c);
    rd(12'h880); rd(12'h802); rd(12'h004);
    // R4: disabled scheduler ignores requests
    cur_req = "R4";
    run(10, 1);
    // R3: enable with last index 59
    cur_req = "R3";
    wr(12'h000, 32'h8000_003b);
    rd(12'h000);
    // R5 / R6 / R7: walk with random and full requests
    cur_req = "R5";
    run(150, 0);
    cur_req = "R6";
    run(40, 2);
    run(60, 0);
    cur_req = "R7";
    run(130, 1);
    // R4: disable and keep requests high
    cur_req = "R4";
    wr(12'h000, 32'h0000_0000);
    run(20, 1);
    rd(12'h000);
    // R8: restart from entry 0, including a rewrite mid-walk
    cur_req = "R8";
    wr(12'h000, 32'h8000_0005);
    run(3, 1);
    wr(12'h000, 32'h8000_0005);
    run(10, 1);
    // R10: table rewrite while running shows on next visit
    cur_req = "R10";
    tx_req = '1; rx_req = '1;
    wr(12'h800, {8'h89, 8'h03, 8'h87, 8'h02});
    run(14, 1);
    rd(12'h800);
    // R9: whole table including out-of-range channels
    cur_req = "R9";
    wr(12'h000, 32'h8000_007f);
    run(300, 1);
    run(200, 0);
    // R7: last index zero repeats entry 0
    cur_req = "R7";
    wr(12'h000, 32'h8000_0000);
    run(8, 1);
    rd(12'h000);
    run(2, 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule